// File: doc/BRIEF.md
# Complementary Gate Pair Dead-Time Inserter

This block turns one reference PWM waveform into a pair of complementary gate drive signals, a high-side output that follows the reference and a low-side output that follows its inverse. On every change of the reference, the output that is about to switch off drops on the next clock edge. The output that is about to switch on is held off until a programmed dead interval has elapsed, so the two switches of a half bridge are never driven together.

The length of the dead interval comes from an 8-bit code that is decoded into four ranges. Each range has its own step size, measured in ticks of a dead-time clock enable, so fine resolution is available at short intervals and a long reach at long ones. The decoded count is captured when an interval starts and is counted down on each tick. An output enable forces both gates off and clears the countdown. When the enable returns, the output that matches the reference switches on only after a full dead interval.

Internally a five-state machine drives the outputs. `ST_OFF` holds both gates off. `ST_LO_ON` drives the low side and `ST_HI_ON` drives the high side. `ST_DT_RISE` and `ST_DT_FALL` are the dead intervals before the high side and before the low side switch on. The transitions are as follows. `ST_OFF` goes to `ST_DT_RISE` or `ST_DT_FALL`, chosen by the reference, when enabled. `ST_LO_ON` goes to `ST_DT_RISE` when the reference is high. `ST_DT_RISE` goes to `ST_HI_ON` when the count has expired, or back to `ST_LO_ON` when the reference is low again. `ST_HI_ON` goes to `ST_DT_FALL` when the reference is low. `ST_DT_FALL` goes to `ST_LO_ON` when the count has expired, or back to `ST_HI_ON` when the reference is high again. Every state goes to `ST_OFF` when the enable is low. A reversal of the reference takes priority over expiry of the count.

Top module: `deadtime_pair`

## Requirements
- R1: Codes with bit 7 clear give a dead count equal to the code value (0 to 127 ticks).
- R2: Codes with bits 7:5 equal to 10x give a dead count of (64 + bits 5:0) × 2 ticks.
- R3: Codes with bits 7:5 equal to 110 give a dead count of (64 + bits 4:0 − 32) × 8, that is (32 + bits 4:0) × 8 ticks.
- R4: Codes with bits 7:5 equal to 111 give a dead count of (32 + bits 4:0) × 16 ticks.
- R5: When the reference rises, gate_lo goes low at the next clock edge. With tick_en held high and a dead count D, gate_hi goes high D+1 clock edges after gate_lo fell.
- R6: When the reference falls, the roles of R5 are exchanged: gate_hi goes low at the next edge and gate_lo goes high D+1 edges later.
- R7: gate_hi and gate_lo are never high in the same cycle.
- R8: If the reference returns to its previous level before the dead count expires, the delayed output never asserts and the other output turns back on at the next edge. This also holds when the return coincides with expiry.
- R9: While tick_en is low, the dead count does not advance and the delayed output stays low.
- R10: While out_en is low, both outputs are low from the next edge and the count is cleared. When out_en returns, the output that matches the reference turns on only after a full dead interval.
- R11: The code is captured when a dead interval starts. Changing it during the interval does not change that interval.
- R12: During and after reset, with out_en low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Dead-time clock enable, one tick per high cycle |
| pwm_ref | input | 1 | Reference PWM waveform |
| dt_code | input | 8 | Encoded dead interval |
| out_en | input | 1 | Output enable; low forces both gates off |
| gate_hi | output | 1 | High-side gate drive, follows the reference |
| gate_lo | output | 1 | Low-side gate drive, follows the inverted reference |

## Verification
Two pairs of events can fall in the same cycle: expiry of the countdown with a reversal of the reference, and a running dead interval with the enable dropping. The bench provokes the first with a zero code and a one-cycle reference pulse. It passes when the high side never asserts and the low side returns on the following edge. It provokes the second by removing out_en partway through a long interval. It passes when both gates are off on the next edge and the restart takes the full programmed count, measured in clock edges at the ports.

// File: rtl/deadtime_pkg.sv
package deadtime_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_LO_ON   = 3'd1,
        ST_DT_RISE = 3'd2,
        ST_HI_ON   = 3'd3,
        ST_DT_FALL = 3'd4
    } dt_state_e;

    function automatic logic is_dead(input dt_state_e s);
        return (s == ST_DT_RISE) || (s == ST_DT_FALL);
    endfunction

endpackage

// File: rtl/dt_code_decode.sv
// Piecewise decode of the dead-interval code into a tick count.
module dt_code_decode #(
    parameter int CODE_W = 8,
    localparam int CNT_W = CODE_W + 2
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  ticks
);

    always_comb begin
        unique casez (code[CODE_W-1 -: 3])
            3'b0??:  ticks = CNT_W'(code[CODE_W-2:0]);
            // leading one supplies the range base, shift gives the step
            3'b10?:  ticks = CNT_W'({1'b1, code[CODE_W-3:0]}) << 1;
            3'b110:  ticks = CNT_W'({1'b1, code[CODE_W-4:0]}) << 3;
            default: ticks = CNT_W'({1'b1, code[CODE_W-4:0]}) << 4;
        endcase
    end

endmodule

// File: rtl/dt_down_counter.sv
// Loadable down-counter advanced by the dead-time tick.
module dt_down_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             expired
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/dt_phase_fsm.sv
// Sequencing of the complementary pair around reference edges.
module dt_phase_fsm
    import deadtime_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic out_en,
    input  logic ref_in,
    input  logic expired,
    output logic load,
    output logic drv_hi,
    output logic drv_lo
);

    dt_state_e state_q;
    dt_state_e state_d;

    // next-state selection; a reversal of the reference beats expiry
    always_comb begin
        state_d = state_q;
        if (!out_en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:     state_d = ref_in ? ST_DT_RISE : ST_DT_FALL;
                ST_LO_ON:   if (ref_in) state_d = ST_DT_RISE;
                ST_DT_RISE: begin
                    if (!ref_in)      state_d = ST_LO_ON;
                    else if (expired) state_d = ST_HI_ON;
                end
                ST_HI_ON:   if (!ref_in) state_d = ST_DT_FALL;
                ST_DT_FALL: begin
                    if (ref_in)       state_d = ST_HI_ON;
                    else if (expired) state_d = ST_LO_ON;
                end
                default:    state_d = ST_OFF;
            endcase
        end
    end

    // a fresh interval starts whenever a dead state is entered
    assign load = is_dead(state_d) && (state_d != state_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // registered gate drives taken from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_hi <= 1'b0;
            drv_lo <= 1'b0;
        end else begin
            drv_hi <= (state_d == ST_HI_ON);
            drv_lo <= (state_d == ST_LO_ON);
        end
    end

endmodule

// File: rtl/deadtime_pair.sv
module deadtime_pair #(
    parameter int CODE_W = 8,
    localparam int CNT_W = CODE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              pwm_ref,
    input  logic [CODE_W-1:0] dt_code,
    input  logic              out_en,
    output logic              gate_hi,
    output logic              gate_lo
);

    logic [CNT_W-1:0] dt_ticks;
    logic [CNT_W-1:0] dt_cnt;
    logic             dt_expired;
    logic             dt_load;

    dt_code_decode #(.CODE_W(CODE_W)) u_decode (
        .code  (dt_code),
        .ticks (dt_ticks)
    );

    dt_down_counter #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!out_en),
        .load     (dt_load),
        .load_val (dt_ticks),
        .tick     (tick_en),
        .cnt      (dt_cnt),
        .expired  (dt_expired)
    );

    dt_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .out_en  (out_en),
        .ref_in  (pwm_ref),
        .expired (dt_expired),
        .load    (dt_load),
        .drv_hi  (gate_hi),
        .drv_lo  (gate_lo)
    );

endmodule

// File: rtl/deadtime_pair_chk.sv
module deadtime_pair_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             pwm_ref,
    input logic             out_en,
    input logic             gate_hi,
    input logic             gate_lo,
    input logic [CNT_W-1:0] cnt
);

    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    p_disable_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> (!gate_hi && !gate_lo));

    p_lo_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && pwm_ref && gate_lo) |=> !gate_lo);

    p_hi_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && !pwm_ref && gate_hi) |=> !gate_hi);

    p_hi_needs_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> $past(pwm_ref));

    p_tick_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && !tick_en && (cnt != '0) && !gate_hi && !gate_lo)
        |=> $stable(cnt));

endmodule

bind deadtime_pair deadtime_pair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .pwm_ref (pwm_ref),
    .out_en  (out_en),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo),
    .cnt     (dt_cnt)
);

// File: tb/deadtime_pair_tb.sv
module deadtime_pair_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_en;
    logic       pwm_ref;
    logic [7:0] dt_code;
    logic       out_en;
    logic       gate_hi;
    logic       gate_lo;

    int checks = 0;
    int fails = 0;
    int overlaps = 0;

    always #5 clk = ~clk;

    deadtime_pair u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .pwm_ref (pwm_ref),
        .dt_code (dt_code),
        .out_en  (out_en),
        .gate_hi (gate_hi),
        .gate_lo (gate_lo)
    );

    // {code, expected dead count in ticks}
    localparam logic [17:0] VEC [12] = '{
        {8'h00, 10'd0},   {8'h05, 10'd5},   {8'h7F, 10'd127},
        {8'h80, 10'd128}, {8'h81, 10'd130}, {8'hBF, 10'd254},
        {8'hC0, 10'd256}, {8'hC3, 10'd280}, {8'hDF, 10'd504},
        {8'hE0, 10'd512}, {8'hE1, 10'd528}, {8'hFF, 10'd1008}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(negedge clk) if (gate_hi && gate_lo) overlaps++;

    function automatic string range_req(input logic [7:0] c);
        if (!c[7]) return "R1";
        if (!c[6]) return "R2";
        if (!c[5]) return "R3";
        return "R4";
    endfunction

    // drive a reference edge and count edges until the delayed output turns on
    task automatic measure_edge(input logic new_ref, input int exp, input string req,
                                input bit swap, input logic [7:0] late_code);
        int n = 0;
        logic on_o;
        @(negedge clk) pwm_ref = new_ref;
        for (int i = 0; i < exp + 10; i++) begin
            @(negedge clk);
            n++;
            on_o = new_ref ? gate_hi : gate_lo;
            if (n == 1) begin
                chk((new_ref ? gate_lo : gate_hi) == 1'b0, new_ref ? "R5 off" : "R6 off",
                    int'(new_ref ? gate_lo : gate_hi), 0);
                if (swap) dt_code = late_code;
            end
            if (on_o) break;
        end
        chk(n == exp + 2, req, n - 2, exp);
    endtask

    task automatic count_until(input bit want_hi, input int exp, input string req);
        int n = 0;
        for (int i = 0; i < exp + 10; i++) begin
            @(negedge clk);
            n++;
            if (want_hi ? gate_hi : gate_lo) break;
        end
        chk(n == exp + 2, req, n - 2, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        summary();
    end

    initial begin
        int hi_seen;
        rst_n = 1'b0; tick_en = 1'b1; pwm_ref = 1'b0; dt_code = 8'h00; out_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(!gate_hi && !gate_lo, "R12 in reset", {gate_hi, gate_lo}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!gate_hi && !gate_lo, "R12 after reset", {gate_hi, gate_lo}, 0);
        out_en = 1'b1;
        repeat (5) @(negedge clk);
        chk(gate_lo && !gate_hi, "R10 enable low side", {gate_hi, gate_lo}, 1);

        // table walk: every range, both edges
        for (int v = 0; v < 12; v++) begin
            dt_code = VEC[v][17:10];
            measure_edge(1'b1, int'(VEC[v][9:0]), {range_req(VEC[v][17:10]), " R5 rise"}, 1'b0, 8'h00);
            measure_edge(1'b0, int'(VEC[v][9:0]), {range_req(VEC[v][17:10]), " R6 fall"}, 1'b0, 8'h00);
        end

        // R8: pulse shorter than dead time
        dt_code = 8'd20; hi_seen = 0;
        @(negedge clk) pwm_ref = 1'b1;
        repeat (5) begin @(negedge clk); if (gate_hi) hi_seen++; end
        pwm_ref = 1'b0;
        @(negedge clk);
        chk(gate_lo == 1'b1, "R8 low restored", int'(gate_lo), 1);
        repeat (30) begin @(negedge clk); if (gate_hi) hi_seen++; end
        chk(hi_seen == 0, "R8 short pulse hi", hi_seen, 0);

        // R8: reversal in the same cycle as expiry (zero code)
        dt_code = 8'h00; hi_seen = 0;
        @(negedge clk) pwm_ref = 1'b1;
        @(negedge clk) begin if (gate_hi) hi_seen++; pwm_ref = 1'b0; end
        @(negedge clk);
        if (gate_hi) hi_seen++;
        chk(gate_lo == 1'b1, "R8 coincide low", int'(gate_lo), 1);
        chk(hi_seen == 0, "R8 coincide hi", hi_seen, 0);
        repeat (3) @(negedge clk);

        // R9: tick held low freezes the interval
        dt_code = 8'd3; hi_seen = 0;
        @(negedge clk) begin pwm_ref = 1'b1; tick_en = 1'b0; end
        repeat (20) begin @(negedge clk); if (gate_hi) hi_seen++; end
        chk(hi_seen == 0, "R9 frozen", hi_seen, 0);
        tick_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(gate_hi == 1'b0, "R9 third edge", int'(gate_hi), 0);
        @(negedge clk);
        chk(gate_hi == 1'b1, "R9 fourth edge", int'(gate_hi), 1);
        measure_edge(1'b0, 3, "R9 fall after hold", 1'b0, 8'h00);

        // R11: code changed inside the interval
        dt_code = 8'd10;
        measure_edge(1'b1, 10, "R11 late code", 1'b1, 8'h00);
        measure_edge(1'b0, 0, "R11 new code next", 1'b0, 8'h00);

        // R10: disable while high side on, then restart
        dt_code = 8'd5;
        measure_edge(1'b1, 5, "R10 prep", 1'b0, 8'h00);
        @(negedge clk) out_en = 1'b0;
        @(negedge clk);
        chk(!gate_hi && !gate_lo, "R10 forced off", {gate_hi, gate_lo}, 0);
        out_en = 1'b1;
        count_until(1'b1, 5, "R10 restart hi");

        // R10: disable mid interval, counter restarts in full
        dt_code = 8'd100;
        @(negedge clk) pwm_ref = 1'b0;
        repeat (3) @(negedge clk);
        out_en = 1'b0;
        @(negedge clk);
        chk(!gate_hi && !gate_lo, "R10 mid-interval off", {gate_hi, gate_lo}, 0);
        out_en = 1'b1;
        count_until(1'b0, 100, "R10 full restart");

        chk(overlaps == 0, "R7 overlap", overlaps, 0);
        summary();
    end

endmodule